// File: doc/BRIEF.md
# Zero-turnaround flow-through synchronous SRAM

This block is a synthesizable model of a small synchronous static memory built for full bus use. Each rising clock edge captures an address and its control signals. The data for that operation moves in the cycle that follows. A read drives its word straight out of the array during that cycle, with no output register. A write takes its data from the input bus at the next edge. Because reads and writes follow the same one-cycle offset, any mix of the two can be issued on consecutive cycles, and the bus never needs an idle turnaround cycle.

An operation starts on an edge where the load control is low and all three chip enables are active. On the following edges, holding load high steps a two-bit burst counter, which gives up to four word addresses in either linear or interleaved order. A clock-hold input freezes every internal register. An asynchronous output enable can turn the output drivers off at any moment. The bidirectional data bus is modelled as three ports: an input, an output and an output-enable.

Top module: `flowthru_sram`

## Requirements
- R1: When an operation starts as a read at rising edge k (load_n low, chip enables active, wr_n high), then during the cycle after edge k dq_out carries the stored word at the captured address, and dq_oe is high while oe_n is low.
- R2: When an operation starts as a write at edge k (wr_n low), then at edge k+1 dq_in is sampled. Byte lane i (bits 8i+7..8i) is stored only if byte_we_n[i] was low at edge k. All other lanes keep their old contents.
- R3: Reads and writes can start on any mix of consecutive edges with no idle cycle. A read started on the edge that commits a write to the same address returns the newly written word.
- R4: At an edge where clk_hold is high, every input is ignored and all internal state keeps its value. This covers the pending operation, the burst counter and the array, so a pending write does not commit. dq_out does not change across the held edge.
- R5: A new operation starts only when load_n is low and en_a_n = 0, en_b = 1 and en_c_n = 0 together. An edge with load_n low and any enable inactive starts nothing and ends any burst, so later edges with load_n high start nothing until the next start.
- R6: An operation already in the data phase still completes when the next edge is a deselect. In particular, a pending write stores its data at that edge.
- R7: dq_oe is low in the cycle after an edge that starts a write or that deselects.
- R8: While oe_n is high, dq_oe is low at once, in any pipeline state. When oe_n goes low again during a read data phase, the read word is driven again at once.
- R9: On each edge with load_n high during a burst, the two address LSBs advance from the start address s by the step count n modulo 4. The step is (s + n) mod 4 when order_lin was 1 at the start edge (linear) and s XOR n when it was 0 (interleaved). The upper address bits and the read/write type stay as they were at the start. Byte lanes are sampled again on each step.
- R10: While rst_n is low, no operation is pending and dq_oe is low. After reset, edges with load_n high start nothing. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| clk_hold | input | 1 | High freezes all internal state for that edge |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low loads a new address; high advances a running burst |
| wr_n | input | 1 | Low selects write, high selects read, at a start edge |
| byte_we_n | input | LANES | Per-lane write enable, active low |
| order_lin | input | 1 | Burst order at a start edge: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data, sampled one edge after its address |
| dq_out | output | LANES*LANE_W | Read data, valid in the cycle after its address |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
Read results (dq_out and dq_oe) are due in the cycle that directly follows the edge that captured their address. Write data is taken at the edge after that, and its effect shows on the next read of the same word. The driver applies each cycle's inputs at the falling edge. It pushes the expected bus state for the cycle after the coming rising edge into a queue. The monitor pops and compares one entry 1 ns after every rising edge, so every check falls inside the data phase it belongs to. Held edges push a copy of the previous expectation, and the output-enable checks toggle oe_n inside a data phase and sample within the same half cycle.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
  localparam int BURST_LEN = 4;
  localparam int BURST_W   = $clog2(BURST_LEN);

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;

  // Low address bits for step n of a burst that began at low bits s (R9)
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] s,
    input logic [BURST_W-1:0] n,
    input burst_order_e       ord
  );
    return (ord == ORD_LINEAR) ? BURST_W'(s + n) : (s ^ n);
  endfunction
endpackage

// File: rtl/fts_burst_gen.sv
`timescale 1ns/1ps
// Decides, for the coming edge, whether an operation enters the data
// phase and at which address; keeps the burst context between edges.
module fts_burst_gen
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load_n,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr,
  output logic              nx_valid,
  output logic              nx_wr,
  output logic [ADDR_W-1:0] nx_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               act_q;
  logic               wr_q;
  burst_order_e       ord_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;
  logic               start;
  logic               advance;
  burst_order_e       ord_in;
  logic [HI_W-1:0]    base_hi;

  assign ord_in  = order_lin ? ORD_LINEAR : ORD_INTERLEAVE;
  assign base_hi = base_q[ADDR_W-1:BURST_W];

  always_comb begin
    start    = !load_n && sel_ok;          // R5
    advance  = load_n && act_q;            // R9
    cnt_nx   = cnt_q + 1'b1;
    nx_valid = start || advance;
    nx_wr    = start ? !wr_n : wr_q;
    nx_addr  = start ? addr
                     : {base_hi, burst_lo(base_q[BURST_W-1:0], cnt_nx, ord_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;                      // R10
      wr_q   <= 1'b0;
      ord_q  <= ORD_LINEAR;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin               // R4: nothing moves while held
      if (start) begin
        act_q  <= 1'b1;
        wr_q   <= !wr_n;
        ord_q  <= ord_in;
        base_q <= addr;
        cnt_q  <= '0;
      end else if (!load_n) begin
        act_q  <= 1'b0;                    // R5: deselect ends the burst
      end else if (act_q) begin
        cnt_q  <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/fts_op_stage.sv
`timescale 1ns/1ps
// Single data-phase register shared by reads and writes.
module fts_op_stage #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              nx_valid,
  input  logic              nx_wr,
  input  logic [ADDR_W-1:0] nx_addr,
  input  logic [LANES-1:0]  byte_we_n,
  output logic              stg_valid,
  output logic              stg_wr,
  output logic [ADDR_W-1:0] stg_addr,
  output logic [LANES-1:0]  stg_lanes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;                   // R10
      stg_wr    <= 1'b0;
      stg_addr  <= '0;
      stg_lanes <= '0;
    end else if (step) begin
      stg_valid <= nx_valid;
      stg_wr    <= nx_wr;
      stg_addr  <= nx_addr;
      stg_lanes <= ~byte_we_n;             // R2: lanes captured with address
    end
  end
endmodule

// File: rtl/fts_byte_array.sv
`timescale 1ns/1ps
// Word array split into independently written byte lanes, with a
// combinational read port for flow-through output.
module fts_byte_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) begin
        bank[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/flowthru_sram.sv
`timescale 1ns/1ps
// Flow-through synchronous SRAM with no read/write turnaround cycles.
// The address phase is at edge k, the data phase is in the cycle after k,
// and write data commits at edge k+1.
module flowthru_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_hold,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    load_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        byte_we_n,
  input  logic                    order_lin,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DW = LANES * LANE_W;

  logic              step;
  logic              sel_ok;
  logic              nx_valid;
  logic              nx_wr;
  logic [ADDR_W-1:0] nx_addr;
  logic              stg_valid;
  logic              stg_wr;
  logic [ADDR_W-1:0] stg_addr;
  logic [LANES-1:0]  stg_lanes;
  logic              commit;
  logic              rd_phase;
  logic [DW-1:0]     rdata;

  assign step   = !clk_hold;                          // R4
  assign sel_ok = !en_a_n && en_b && !en_c_n;         // R5

  fts_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .load_n    (load_n),
    .sel_ok    (sel_ok),
    .wr_n      (wr_n),
    .order_lin (order_lin),
    .addr      (addr),
    .nx_valid  (nx_valid),
    .nx_wr     (nx_wr),
    .nx_addr   (nx_addr)
  );

  fts_op_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .nx_valid  (nx_valid),
    .nx_wr     (nx_wr),
    .nx_addr   (nx_addr),
    .byte_we_n (byte_we_n),
    .stg_valid (stg_valid),
    .stg_wr    (stg_wr),
    .stg_addr  (stg_addr),
    .stg_lanes (stg_lanes)
  );

  // R2/R6: the pending write commits at the next unheld edge, whatever
  // the control inputs at that edge say.
  assign commit = step && stg_valid && stg_wr;

  fts_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_en   (commit),
    .lane_en (stg_lanes),
    .waddr   (stg_addr),
    .wdata   (dq_in),
    .raddr   (stg_addr),
    .rdata   (rdata)
  );

  // R1/R3/R7/R8: drive only in a read data phase, gated asynchronously.
  assign rd_phase = stg_valid && !stg_wr;
  assign dq_out   = rd_phase ? rdata : '0;
  assign dq_oe    = rd_phase && !oe_n;
endmodule

// File: rtl/fts_checker.sv
`timescale 1ns/1ps
module fts_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_hold,
  input logic          en_a_n,
  input logic          en_b,
  input logic          en_c_n,
  input logic          load_n,
  input logic          wr_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  logic sel_ok;
  logic go;
  assign sel_ok = !en_a_n && en_b && !en_c_n;
  assign go     = !clk_hold && !load_n && sel_ok;

  p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wr_n) |=> (oe_n || dq_oe));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |=> $stable(dq_out));

  p_burst_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && !load_n && !sel_ok) ##1 (!clk_hold && load_n) |=> !dq_oe);

  p_hiz_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_n) |=> !dq_oe);

  p_hiz_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && !load_n && !sel_ok) |=> !dq_oe);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r10: assert (!dq_oe);
    end
  end
endmodule

bind flowthru_sram fts_checker #(.DW(LANES*LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_hold (clk_hold),
  .en_a_n   (en_a_n),
  .en_b     (en_b),
  .en_c_n   (en_c_n),
  .load_n   (load_n),
  .wr_n     (wr_n),
  .oe_n     (oe_n),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe)
);

// File: tb/flowthru_sram_tb_top.sv
`timescale 1ns/1ps
module flowthru_sram_tb_top;
  localparam int AW = 6, NL = 4, LW = 8, DW = NL * LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, clk_hold, en_a_n, en_b, en_c_n, load_n, wr_n;
  logic [NL-1:0] byte_we_n;
  logic          order_lin, oe_n, dq_oe;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;

  flowthru_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .en_a_n(en_a_n),
    .en_b(en_b), .en_c_n(en_c_n), .load_n(load_n), .wr_n(wr_n),
    .byte_we_n(byte_we_n), .order_lin(order_lin), .addr(addr),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct {
    bit            oe;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model, derived from the requirements
  logic [DW-1:0] mm [DEPTH];
  bit            m_valid, m_wr, b_act, b_wr, b_lin;
  logic [AW-1:0] m_addr, b_base;
  logic [NL-1:0] m_be;
  logic [1:0]    b_cnt;

  function automatic logic [DW-1:0] pat(input int i);
    return {8'(i), 8'(i) ^ 8'h5A, ~8'(i), 8'(i + 8'h33)};
  endfunction

  function automatic logic [1:0] lo(input logic [1:0] s, input logic [1:0] n, input bit lin);
    return lin ? 2'(s + n) : (s ^ n);
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus; wd is write data for the pending op.
  task automatic cyc(input string tag, input bit hold, input bit ldn, input bit [2:0] en,
                     input bit wrn, input int a, input bit [NL-1:0] ben, input bit lin,
                     input logic [DW-1:0] wd, input bit oen);
    @(negedge clk);
    clk_hold = hold; load_n = ldn; en_a_n = !en[0]; en_b = en[1]; en_c_n = !en[2];
    wr_n = wrn; addr = AW'(a); byte_we_n = ben; order_lin = lin; dq_in = wd; oe_n = oen;
    if (!hold) begin
      if (m_valid && m_wr)
        for (int l = 0; l < NL; l++)
          if (m_be[l]) mm[m_addr][l*LW +: LW] = wd[l*LW +: LW];
      if (!ldn && en == 3'b111) begin
        b_act = 1; b_base = AW'(a); b_cnt = 0; b_wr = !wrn; b_lin = lin;
        m_valid = 1; m_wr = !wrn; m_addr = AW'(a); m_be = ~ben;
      end else if (!ldn) begin
        b_act = 0; m_valid = 0;
      end else if (b_act) begin
        b_cnt = b_cnt + 1;
        m_addr = {b_base[AW-1:2], lo(b_base[1:0], b_cnt, b_lin)};
        m_valid = 1; m_wr = b_wr; m_be = ~ben;
      end else begin
        m_valid = 0;
      end
    end
    sb.push_back('{m_valid && !m_wr && !oen, mm[m_addr], tag});
  endtask

  task automatic op(input string tag, input bit wrn, input int a, input logic [DW-1:0] wd,
                    input bit [NL-1:0] ben = '0, input bit lin = 1);
    cyc(tag, 0, 0, 3'b111, wrn, a, ben, lin, wd, 0);
  endtask

  task automatic adv(input string tag, input logic [DW-1:0] wd, input bit [NL-1:0] ben = '0);
    cyc(tag, 0, 1, 3'b111, 1, 0, ben, 1, wd, 0);
  endtask

  task automatic desel(input string tag, input bit [2:0] en, input logic [DW-1:0] wd);
    cyc(tag, 0, 0, en, 1, 0, '0, 1, wd, 0);
  endtask

  // Monitor: one expectation per cycle, sampled inside the data phase
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (dq_oe !== e.oe || (e.oe && dq_out !== e.d)) begin
          errors++;
          $display("FAIL %s: actual oe=%b data=%h expected oe=%b data=%h",
                   e.tag, dq_oe, dq_out, e.oe, e.d);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1; clk_hold = 0; en_a_n = 1; en_b = 0; en_c_n = 1; load_n = 1; wr_n = 1;
    byte_we_n = '1; order_lin = 1; addr = '0; oe_n = 0; dq_in = '0;
    m_valid = 0; m_wr = 0; b_act = 0; b_wr = 0; b_lin = 1; m_addr = '0; b_base = '0;
    m_be = '0; b_cnt = '0;
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 chk("R10 bus idle in reset", dq_oe == 1'b0, DW'(dq_oe), '0);
    @(negedge clk) rst_n = 1;

    cyc("R10 advance after reset starts nothing", 0, 1, 3'b111, 1, 9, '0, 1, '0, 0);

    // Fill the whole array with back-to-back writes (R2, R3, R7)
    for (int i = 0; i < DEPTH; i++) op("R2 fill write", 0, i, (i == 0) ? '0 : pat(i - 1));
    op("R1 read after fill", 1, 0, pat(DEPTH - 1));
    for (int i = 1; i < 8; i++) op("R1 read", 1, i, '0);

    // R3: read/write mix, read right after write of the same word
    op("R3 write 10", 0, 10, '0);
    op("R3 read 10 after write", 1, 10, 32'h1234_5678);
    op("R3 write 11", 0, 11, '0);
    op("R3 write 12", 0, 12, 32'h0BAD_0011);
    op("R3 read 11", 1, 11, 32'h0BAD_0012);
    op("R3 read 12", 1, 12, '0);

    // R2: only lanes 0 and 2 stored
    op("R2 partial write 20", 0, 20, '0, 4'b1010);
    op("R2 read 20 lanes", 1, 20, 32'hDEAD_BEEF);
    op("R2 read 20 again", 1, 20, '0);

    // R4: held read and held write
    op("R4 read 5", 1, 5, '0);
    for (int h = 0; h < 3; h++) cyc("R4 held read", 1, 0, 3'b111, 0, 6, '0, 1, 32'hFFFF_FFFF, 0);
    op("R4 read 6 untouched", 1, 6, '0);
    op("R4 write 30", 0, 30, '0);
    for (int h = 0; h < 2; h++) cyc("R4 held write", 1, 0, 3'b111, 0, 31, '0, 1, 32'h1111_1111, 0);
    op("R4 read 30 after held write", 1, 30, 32'h600D_F00D);
    op("R4 read 31 untouched", 1, 31, '0);

    // R5/R6/R7: deselect behaviour on each enable
    op("R9 read burst 40", 1, 40, '0);
    adv("R9 linear step", '0);
    desel("R5 R7 deselect en_a", 3'b110, '0);
    adv("R5 burst ended", '0);
    adv("R5 still idle", '0);
    op("R6 write 41", 0, 41, '0);
    desel("R6 deselect en_b pending write", 3'b101, 32'hCAFE_0041);
    op("R6 read 41", 1, 41, '0);
    op("R7 write starts", 0, 2, '0);
    op("R7 read 3", 1, 3, 32'h0000_0202);
    desel("R7 deselect en_c", 3'b011, '0);
    op("R7 read 2", 1, 2, '0);

    // R9: burst orders
    op("R9 linear start 49", 1, 49, '0, '0, 1);
    for (int s = 0; s < 4; s++) adv("R9 linear step", '0);
    op("R9 interleaved start 49", 1, 49, '0, '0, 0);
    for (int s = 0; s < 3; s++) adv("R9 interleaved step", '0);
    op("R9 interleaved write start 53", 0, 53, '0, '0, 0);
    adv("R9 write burst step", 32'hB000_0053);
    adv("R9 write burst step", 32'hB000_0052);
    adv("R9 write burst step", 32'hB000_0055);
    op("R9 read 53", 1, 53, 32'hB000_0054);
    op("R9 read 52", 1, 52, '0);
    op("R9 read 55", 1, 55, '0);
    op("R9 read 54", 1, 54, '0);

    // R8: output enable
    cyc("R8 oe_n high on read", 0, 0, 3'b111, 1, 7, '0, 1, '0, 1);
    op("R8 read 8", 1, 8, '0);
    @(posedge clk);
    #1.5 oe_n = 1;
    #0.5 chk("R8 async off", dq_oe == 1'b0, DW'(dq_oe), '0);
    oe_n = 0;
    #0.2 chk("R8 async on", dq_oe == 1'b1 && dq_out == pat(8), dq_out, pat(8));

    desel("R7 idle end", 3'b000, '0);
    desel("R7 idle end", 3'b000, '0);
    repeat (3) @(posedge clk);
    #2 chk("scoreboard drained", sb.size() == 0, DW'(sb.size()), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule